// File: doc/BRIEF.md
# Eight-Channel Edge-Aligned PWM Timer

This block generates up to eight pulse-width-modulated outputs that all share one up-counter and therefore one period. The counter is advanced by a selectable tick source (every system clock, a fixed-rate enable input or an external enable input). A power-of-two prescaler divides that source. The counter climbs from a programmable start value to a programmable top value, then reloads the start value.

Each channel compares the shared count against its own compare value to form an edge-aligned pulse. The pulse may then be inverted. A per-channel mask can override it with a programmable idle level. Software programs the block through a simple 32-bit register port with a one-cycle read latency. The top value and the compare values are buffered and only take effect when the counter wraps, so a period is never cut short.

Top module: `pwm8_timer`

## Requirements
- R1: The prescale field is bits 2:0 of the control register (offset 0x00), written PS. The counter advances once for every 2^PS cycles in which the selected tick source is active. The prescale phase restarts at each advance.
- R2: The source field is bits 4:3 of the control register. Its values select the tick source as follows: 0 stops the counter and holds all outputs steady, 1 uses every clock, 2 uses `fixTickEn` and 3 uses `extTickEn`.
- R3: On each advance, a count below the active top value increases by exactly one.
- R4: On an advance where the count is at or above the active top value, the count is replaced by the start register (offset 0x4C). The period is therefore top minus start plus one advances.
- R5: A channel is in edge-aligned PWM mode when bits 5 and 3 of its mode register (offset 0x0C + 8n) are both set. In that mode its pulse is high while the count is below the active compare value. A compare above the top value gives a constantly high pulse. In any other mode the pulse is low.
- R6: Bit n of the invert register (offset 0x70) inverts channel n's pulse.
- R7: Bit n of the mask register (offset 0x60) drives output n to bit n of the idle-level register (offset 0x5C). The mask register resets to 0xFF and the idle-level register resets to 0x00.
- R8: Writes to the top register (offset 0x08) and to a compare register (offset 0x10 + 8n) are held back and take effect only at the next counter wrap.
- R9: Every mapped register reads back its written field value one clock after its address is presented. The field widths are: control 5 bits, top, start and compare 16 bits, mode bits 5:2, and 8 bits for the invert, mask and idle-level registers.
- R10: Any address not listed above reads as zero.
- R11: After reset the count is zero, all outputs are low and all registers except the mask read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fixTickEn | input | 1 | Fixed-rate tick enable (source 2) |
| extTickEn | input | 1 | External tick enable (source 3) |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, one cycle after the address |
| pwmOut | output | 8 | Channel outputs |

## Verification
The channels are run with compare values at zero, inside the period, at the top value and above it. This separates the 0 %, partial and 100 % duty cases, and it exposes off-by-one errors at the wrap. Prescale settings of 0, 2, 3 and 1 are driven with both enable inputs toggling pseudo-randomly, which tells the source mux apart from the divider. The top and compare values are rewritten in the middle of a period to show whether they are buffered until the wrap. Mixed invert, mask and idle-level patterns check that the output stage applies inversion before masking. A non-zero start value checks the reload path.

// File: rtl/pwm8_pkg.sv
`timescale 1ns/1ps
package pwm8_pkg;
  // register byte offsets
  localparam int CTRL_OFF  = 'h00;
  localparam int TOP_OFF   = 'h08;
  localparam int MODE_BASE = 'h0C;
  localparam int CMP_BASE  = 'h10;
  localparam int CH_STRIDE = 8;
  localparam int START_OFF = 'h4C;
  localparam int IDLE_OFF  = 'h5C;
  localparam int MASK_OFF  = 'h60;
  localparam int INV_OFF   = 'h70;

  // strobes from control to datapath
  typedef struct packed {
    logic srcTick;   // selected source active this cycle
    logic cntTick;   // counter advances this cycle
  } strobe_t;
endpackage

// File: rtl/pwm8_ctrl.sv
`timescale 1ns/1ps
module pwm8_ctrl
  import pwm8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fixTickEn,
  input  logic                    extTickEn,
  input  logic [AW-1:0]           busAddr,
  input  logic                    busWrEn,
  input  logic [31:0]             busWrData,
  output logic [31:0]             busRdData,
  output logic [CW-1:0]           topReg,
  output logic [CW-1:0]           startReg,
  output logic [NCH-1:0][CW-1:0]  cmpReg,
  output logic [NCH-1:0]          pwmModeOn,
  output logic [NCH-1:0]          invReg,
  output logic [NCH-1:0]          maskReg,
  output logic [NCH-1:0]          idleReg,
  output strobe_t                 strb
);
  localparam int PSW = 8;

  logic [4:0]           ctrlReg;
  logic [NCH-1:0][3:0]  modeReg;     // holds mode bits 5:2
  logic [NCH-1:0]       modeHit, cmpHit;
  logic [PSW-1:0]       psCnt, psLim;
  logic [31:0]          rdNext;
  logic                 mapped;
  logic                 unusedWr;

  assign unusedWr = &{1'b0, busWrData};

  logic hitCtrl, hitTop, hitStart, hitIdle, hitMask, hitInv;
  assign hitCtrl  = busAddr == AW'(CTRL_OFF);
  assign hitTop   = busAddr == AW'(TOP_OFF);
  assign hitStart = busAddr == AW'(START_OFF);
  assign hitIdle  = busAddr == AW'(IDLE_OFF);
  assign hitMask  = busAddr == AW'(MASK_OFF);
  assign hitInv   = busAddr == AW'(INV_OFF);

  // shared registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      topReg   <= '0;
      startReg <= '0;
      idleReg  <= '0;
      maskReg  <= '1;
      invReg   <= '0;
    end else if (busWrEn) begin
      if (hitCtrl)  ctrlReg  <= busWrData[4:0];
      if (hitTop)   topReg   <= busWrData[CW-1:0];
      if (hitStart) startReg <= busWrData[CW-1:0];
      if (hitIdle)  idleReg  <= busWrData[NCH-1:0];
      if (hitMask)  maskReg  <= busWrData[NCH-1:0];
      if (hitInv)   invReg   <= busWrData[NCH-1:0];
    end
  end

  // per-channel registers
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign modeHit[i]   = busAddr == AW'(MODE_BASE + CH_STRIDE * i);
    assign cmpHit[i]    = busAddr == AW'(CMP_BASE + CH_STRIDE * i);
    assign pwmModeOn[i] = modeReg[i][3] & modeReg[i][1];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeReg[i] <= '0;
        cmpReg[i]  <= '0;
      end else if (busWrEn) begin
        if (modeHit[i]) modeReg[i] <= busWrData[5:2];
        if (cmpHit[i])  cmpReg[i]  <= busWrData[CW-1:0];
      end
    end
  end

  // read mux, registered
  always_comb begin
    rdNext = '0;
    if (hitCtrl)  rdNext = {27'b0, ctrlReg};
    if (hitTop)   rdNext = {{(32-CW){1'b0}}, topReg};
    if (hitStart) rdNext = {{(32-CW){1'b0}}, startReg};
    if (hitIdle)  rdNext = {{(32-NCH){1'b0}}, idleReg};
    if (hitMask)  rdNext = {{(32-NCH){1'b0}}, maskReg};
    if (hitInv)   rdNext = {{(32-NCH){1'b0}}, invReg};
    for (int i = 0; i < NCH; i++) begin
      if (modeHit[i]) rdNext = {26'b0, modeReg[i], 2'b0};
      if (cmpHit[i])  rdNext = {{(32-CW){1'b0}}, cmpReg[i]};
    end
  end

  assign mapped = hitCtrl | hitTop | hitStart | hitIdle | hitMask | hitInv
                | (|modeHit) | (|cmpHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else       busRdData <= rdNext;
  end

  // tick source and prescaler
  always_comb begin
    unique case (ctrlReg[4:3])
      2'd0: strb.srcTick = 1'b0;
      2'd1: strb.srcTick = 1'b1;
      2'd2: strb.srcTick = fixTickEn;
      default: strb.srcTick = extTickEn;
    endcase
  end

  assign psLim        = (PSW'(1) << ctrlReg[2:0]) - PSW'(1);
  assign strb.cntTick = strb.srcTick && (psCnt >= psLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              psCnt <= '0;
    else if (strb.cntTick)  psCnt <= '0;
    else if (strb.srcTick)  psCnt <= psCnt + PSW'(1);
  end

  p_prescale_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntTick |=> psCnt == '0);
  p_stop_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[4:3] == 2'd0) |-> !strb.cntTick);
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |=> busRdData == '0);
endmodule

// File: rtl/pwm8_dp.sv
`timescale 1ns/1ps
module pwm8_dp
  import pwm8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [CW-1:0]           topReg,
  input  logic [CW-1:0]           startReg,
  input  logic [NCH-1:0][CW-1:0]  cmpReg,
  input  logic [NCH-1:0]          pwmModeOn,
  input  logic [NCH-1:0]          invReg,
  input  logic [NCH-1:0]          maskReg,
  input  logic [NCH-1:0]          idleReg,
  output logic [NCH-1:0]          pwmOut
);
  logic [CW-1:0]           cnt, topAct;
  logic [NCH-1:0][CW-1:0]  cmpAct;
  logic [NCH-1:0]          rawPulse;
  logic                    atTop, wrapNow;

  assign atTop   = cnt >= topAct;
  assign wrapNow = strb.cntTick && atTop;

  // shared counter with buffered top and compares
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      topAct <= '0;
      cmpAct <= '0;
    end else if (wrapNow) begin
      cnt    <= startReg;
      topAct <= topReg;
      cmpAct <= cmpReg;
    end else if (strb.cntTick) begin
      cnt <= cnt + CW'(1);
    end
  end

  // edge-aligned compare, invert, then mask
  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign rawPulse[i] = pwmModeOn[i] && (cnt < cmpAct[i]);
    assign pwmOut[i]   = maskReg[i] ? idleReg[i] : (rawPulse[i] ^ invReg[i]);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntTick |=> $stable(cnt));
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntTick && cnt < topAct) |=> cnt == CW'($past(cnt) + CW'(1)));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntTick && cnt >= topAct) |=> cnt == $past(startReg));
  p_buffered_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cntTick && cnt >= topAct) |=> $stable(topAct));
endmodule

// File: rtl/pwm8_timer.sv
`timescale 1ns/1ps
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fixTickEn,
  input  logic            extTickEn,
  input  logic [AW-1:0]   busAddr,
  input  logic            busWrEn,
  input  logic [31:0]     busWrData,
  output logic [31:0]     busRdData,
  output logic [NCH-1:0]  pwmOut
);
  strobe_t                strb;
  logic [CW-1:0]          topReg, startReg;
  logic [NCH-1:0][CW-1:0] cmpReg;
  logic [NCH-1:0]         pwmModeOn, invReg, maskReg, idleReg;

  pwm8_ctrl #(.NCH(NCH), .CW(CW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .fixTickEn(fixTickEn), .extTickEn(extTickEn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .topReg(topReg), .startReg(startReg),
    .cmpReg(cmpReg), .pwmModeOn(pwmModeOn), .invReg(invReg),
    .maskReg(maskReg), .idleReg(idleReg), .strb(strb)
  );

  pwm8_dp #(.NCH(NCH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .topReg(topReg),
    .startReg(startReg), .cmpReg(cmpReg), .pwmModeOn(pwmModeOn),
    .invReg(invReg), .maskReg(maskReg), .idleReg(idleReg), .pwmOut(pwmOut)
  );
endmodule

// File: tb/pwm8_timer_tb.sv
`timescale 1ns/1ps
module pwm8_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fixTickEn = 1'b0, extTickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  pwmOut;

  pwm8_timer u_dut (
    .clk(clk), .rstN(rstN), .fixTickEn(fixTickEn), .extTickEn(extTickEn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pwmOut(pwmOut)
  );

  always #2.5 clk = ~clk;

  int    nChk = 0, nFail = 0;
  bit    runChk = 0;
  string phase = "R11 reset";

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mCtrl, mTop, mStart, mIdle, mMask, mInv, mPs, mCnt, mTopA;
  int mMode[8], mCmp[8], mCmpA[8];

  task automatic modelReset();
    mCtrl = 0; mTop = 0; mStart = 0; mIdle = 0; mMask = 'hFF; mInv = 0;
    mPs = 0; mCnt = 0; mTopA = 0;
    for (int i = 0; i < 8; i++) begin mMode[i] = 0; mCmp[i] = 0; mCmpA[i] = 0; end
  endtask

  function automatic int readModel(int a);
    if (a == 'h00) return mCtrl;
    if (a == 'h08) return mTop;
    if (a == 'h4C) return mStart;
    if (a == 'h5C) return mIdle;
    if (a == 'h60) return mMask;
    if (a == 'h70) return mInv;
    for (int i = 0; i < 8; i++) begin
      if (a == 'h0C + 8*i) return mMode[i];
      if (a == 'h10 + 8*i) return mCmp[i];
    end
    return 0;
  endfunction

  function automatic int expOut();
    int o = 0;
    for (int i = 0; i < 8; i++) begin
      int b;
      b = (((mMode[i] >> 5) & 1) && ((mMode[i] >> 3) & 1) && (mCnt < mCmpA[i])) ? 1 : 0;
      b = b ^ ((mInv >> i) & 1);
      if ((mMask >> i) & 1) b = (mIdle >> i) & 1;
      o |= b << i;
    end
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int sel, src, lim, a, d;
      sel = (mCtrl >> 3) & 3;
      src = (sel == 1) || (sel == 2 && fixTickEn) || (sel == 3 && extTickEn);
      lim = (1 << (mCtrl & 7)) - 1;
      if (src) begin
        if (mPs >= lim) begin
          mPs = 0;
          if (mCnt >= mTopA) begin
            mCnt = mStart; mTopA = mTop;
            for (int i = 0; i < 8; i++) mCmpA[i] = mCmp[i];
          end else mCnt++;
        end else mPs++;
      end
      if (busWrEn) begin
        a = busAddr; d = busWrData;
        if (a == 'h00) mCtrl = d & 'h1F;
        if (a == 'h08) mTop = d & 'hFFFF;
        if (a == 'h4C) mStart = d & 'hFFFF;
        if (a == 'h5C) mIdle = d & 'hFF;
        if (a == 'h60) mMask = d & 'hFF;
        if (a == 'h70) mInv = d & 'hFF;
        for (int i = 0; i < 8; i++) begin
          if (a == 'h0C + 8*i) mMode[i] = d & 'h3C;
          if (a == 'h10 + 8*i) mCmp[i] = d & 'hFFFF;
        end
      end
    end
  end

  // per-clock output comparison
  always @(negedge clk) if (rstN && runChk) check(phase, int'(pwmOut), expOut());

  // pseudo-random tick enables
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fixTickEn = lfsr[0];
    extTickEn = lfsr[2] & lfsr[7];
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    busAddr = 8'(a); busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(int a, string tag);
    int e;
    @(negedge clk);
    busAddr = 8'(a); busWrEn = 1'b0;
    e = readModel(a);
    @(negedge clk);
    check(tag, int'(busRdData), e);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] held;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 outputs low after reset", int'(pwmOut), 0);
    rdChk('h60, "R7 mask resets to 0xFF");
    rdChk('h5C, "R7 idle level resets to 0");
    rdChk('h00, "R11 control resets to 0");
    rdChk('h08, "R11 top resets to 0");
    runChk = 1;

    // program while stopped, read back
    wr('h08, 9); wr('h4C, 0);
    for (int i = 0; i < 8; i++) wr('h0C + 8*i, 'hFF28);
    wr('h10, 0);  wr('h18, 1); wr('h20, 3);  wr('h28, 5);
    wr('h30, 9);  wr('h38, 10); wr('h40, 11); wr('h48, 4);
    wr('h60, 0);  wr('h5C, 'h00); wr('h70, 'h100);
    rdChk('h08, "R9 top readback");
    rdChk('h2C, "R9 mode field readback");
    rdChk('h40, "R9 compare readback");
    rdChk('h70, "R9 invert readback");
    rdChk('h04, "R10 unmapped 0x04");
    rdChk('h64, "R10 unmapped 0x64");
    rdChk('hFC, "R10 unmapped 0xFC");

    phase = "R3 R4 R5 system clock duty"; wr('h00, 'h08); run(40);
    phase = "R6 inversion";               wr('h70, 'hA5); run(25);
    phase = "R7 masking to idle level";   wr('h5C, 'h3C); wr('h60, 'h0F); run(25);
    wr('h60, 0); wr('h70, 0);
    phase = "R5 non-PWM modes low";       wr('h1C, 'h20); wr('h24, 'h0C); run(25);
    phase = "R8 buffered top and compare"; wr('h08, 14); wr('h10, 7); run(45);
    phase = "R4 non-zero start value";     wr('h4C, 3); run(40);
    phase = "R1 prescale by 4";            wr('h00, 'h0A); run(120);
    phase = "R1 prescale by 8";            wr('h00, 'h0B); run(250);
    phase = "R2 fixed enable source";      wr('h00, 'h11); run(200);
    phase = "R2 external enable source";   wr('h00, 'h18); run(200);
    phase = "R2 stopped";                  wr('h00, 'h00); run(2);
    held = pwmOut; run(30);
    check("R2 outputs frozen while stopped", int'(pwmOut), int'(held));
    rdChk('h00, "R9 control readback");

    runChk = 0;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule